// File: doc/BRIEF.md
# Vector Register-Pair Store Sequencer

This block takes one 32-bit store-pair instruction word and turns it into two 128-bit memory writes. It checks that the word really encodes a vector store pair and that the required features and FP access are enabled. It picks the base from a general register or the stack pointer and adds a signed immediate scaled by 16. It then drives two write beats, one after the other, on a valid/ready memory port. Every beat carries a non-temporal hint, a tag-check flag and a privilege flag.

The surrounding pipeline presents the instruction together with its operands and pulses `issue_i` while the block is idle. The operands are the value of the named base register, the stack pointer and the two vector data values. The block latches everything on that edge, so the operand inputs may change afterwards. There are three possible results. A fault pulse reports a failed feature check, FP check or stack-alignment check. A done pulse follows the second write. A word that does not match the encoding produces no response at all.

Top module: `vpair_store_seq`

## Requirements
- R1: An issue is accepted only while the block is idle and `instr_i[31:22]` equals 10'b1110110000. Within that pattern, bit 26 set marks a vector access and bit 22 clear marks a store. Any other word produces no write and no fault.
- R2: The field layout is fixed. The 7-bit signed immediate sits in bits [21:15] and the base register number in bits [9:5]. The first write address is base + (signed immediate × 16), wrapping modulo 2^64.
- R3: If the base register number is 31, the base is `sp_i`. Otherwise it is `gpr_base_i`.
- R4: Every write beat has `mem_ntemp_o`=1. `mem_tagchk_o` is 1 exactly when the base register number is not 31. `mem_unpriv_o` is the inverse of `uao_i` as sampled at issue.
- R5: The first beat writes `vdata_a_i` to address A. Only after the first beat is accepted does the second beat write `vdata_b_i` to A+16.
- R6: While `mem_valid_o` is high and `mem_ready_i` is low, address, data and attributes stay unchanged.
- R7: `done_o` is high for exactly one cycle, in the cycle after the second beat is accepted.
- R8: If `feat_fp_i` or `feat_unpriv_i` is low, a matching issue raises a one-cycle `undef_o` in the next cycle and no write is made. This check wins over every other check.
- R9: If both features are present but `fp_enable_i` is low, a matching issue raises a one-cycle `fp_trap_o` and no write is made. This check wins over the alignment check.
- R10: If the base register number is 31, `sp_i[3:0]` is nonzero, and the feature and FP checks pass, a one-cycle `align_fault_o` is raised and no write is made. A misaligned general-register base is not faulted.
- R11: An issue while a store is in progress is ignored and does not alter the beats in flight.
- R12: Operands are captured at issue. Later changes on the operand inputs do not change the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Present the instruction and operands |
| instr_i | input | 32 | Instruction word |
| gpr_base_i | input | 64 | Value of the general register named as base |
| sp_i | input | 64 | Stack pointer value |
| vdata_a_i | input | 128 | Data for the first write |
| vdata_b_i | input | 128 | Data for the second write |
| feat_fp_i | input | 1 | FP feature present |
| feat_unpriv_i | input | 1 | Unprivileged-store feature present |
| fp_enable_i | input | 1 | FP access enabled |
| uao_i | input | 1 | User-access override flag |
| mem_ready_i | input | 1 | Memory accepts the current beat |
| mem_valid_o | output | 1 | Write beat valid |
| mem_addr_o | output | 64 | Write byte address |
| mem_wdata_o | output | 128 | Write data |
| mem_ntemp_o | output | 1 | Non-temporal hint |
| mem_tagchk_o | output | 1 | Tag check enable |
| mem_unpriv_o | output | 1 | Access made as unprivileged |
| undef_o | output | 1 | Undefined-instruction fault pulse |
| fp_trap_o | output | 1 | FP-disabled trap pulse |
| align_fault_o | output | 1 | Stack-pointer alignment fault pulse |
| done_o | output | 1 | Store complete pulse |

## Verification
The first beat, or a fault pulse, shows up one cycle after the issuing edge. The second beat appears one cycle after the edge on which the first beat is accepted. `done_o` follows one cycle after the second acceptance and drops again one cycle later. The bench drives inputs on falling edges and samples on the next falling edge after each edge it counts. For a stalled beat it re-samples once per stall cycle. Immediates, base-register numbers, stall lengths and fault combinations are swept. Expected addresses are formed with plain integer arithmetic.

// File: rtl/vps_pkg.sv
package vps_pkg;
  localparam logic [9:0] VPS_OPCODE = 10'b1110110000;
  localparam int         VPS_SP_REG = 31;

  typedef struct packed {
    logic ntemp;
    logic tagchk;
    logic unpriv;
  } vps_attr_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_BEAT0 = 2'd1,
    S_BEAT1 = 2'd2
  } vps_state_e;
endpackage

// File: rtl/vps_decode.sv
module vps_decode
  import vps_pkg::*;
#(
  parameter int IMM_W = 7,
  parameter int REG_W = 5
) (
  input  logic [31:0]      instr_i,
  output logic             match_o,
  output logic [IMM_W-1:0] imm_o,
  output logic [REG_W-1:0] rn_o,
  output logic             base_is_sp_o
);
  function automatic logic opcode_hit(input logic [31:0] w);
    return w[31:22] == VPS_OPCODE;
  endfunction

  logic unused_regs;
  assign unused_regs = ^{instr_i[14:10], instr_i[4:0]};

  assign match_o      = opcode_hit(instr_i);
  assign imm_o        = instr_i[21:15];
  assign rn_o         = instr_i[9:5];
  assign base_is_sp_o = (rn_o == REG_W'(VPS_SP_REG));
endmodule

// File: rtl/vps_agen.sv
module vps_agen #(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 7,
  parameter int SHIFT  = 4
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              base_is_sp_i,
  input  logic [ADDR_W-1:0] gpr_base_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sp_misalign_o
);
  localparam int EXT_W = ADDR_W - IMM_W - SHIFT;

  function automatic logic [ADDR_W-1:0] scaled_offset(input logic [IMM_W-1:0] imm);
    return {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
  endfunction

  logic [ADDR_W-1:0] base_w;
  assign base_w        = base_is_sp_i ? sp_i : gpr_base_i;
  assign addr_o        = base_w + scaled_offset(imm_i);
  assign sp_misalign_o = base_is_sp_i && (sp_i[SHIFT-1:0] != '0);
endmodule

// File: rtl/vps_beat_fsm.sv
module vps_beat_fsm
  import vps_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_a_i,
  input  logic [DATA_W-1:0] data_b_i,
  input  vps_attr_t         attr_i,
  input  logic              ready_i,
  output logic              idle_o,
  output logic              valid_o,
  output logic              second_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output vps_attr_t         attr_o,
  output logic              done_o
);
  localparam int BEAT_BYTES = DATA_W / 8;

  vps_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] da_q, db_q;
  vps_attr_t         attr_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      da_q    <= '0;
      db_q    <= '0;
      attr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_BEAT0;
          addr_q  <= addr_i;
          da_q    <= data_a_i;
          db_q    <= data_b_i;
          attr_q  <= attr_i;
        end
        S_BEAT0: if (ready_i) state_q <= S_BEAT1;
        S_BEAT1: if (ready_i) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idle_o   = (state_q == S_IDLE);
  assign valid_o  = !idle_o;
  assign second_o = (state_q == S_BEAT1);
  assign addr_o   = second_o ? addr_q + ADDR_W'(BEAT_BYTES) : addr_q;
  assign data_o   = second_o ? db_q : da_q;
  assign attr_o   = attr_q;
  assign done_o   = done_q;
endmodule

// File: rtl/vpair_store_seq.sv
module vpair_store_seq
  import vps_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 128,
  parameter int IMM_W  = 7,
  parameter int REG_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [31:0]       instr_i,
  input  logic [ADDR_W-1:0] gpr_base_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [DATA_W-1:0] vdata_a_i,
  input  logic [DATA_W-1:0] vdata_b_i,
  input  logic              feat_fp_i,
  input  logic              feat_unpriv_i,
  input  logic              fp_enable_i,
  input  logic              uao_i,
  input  logic              mem_ready_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_ntemp_o,
  output logic              mem_tagchk_o,
  output logic              mem_unpriv_o,
  output logic              undef_o,
  output logic              fp_trap_o,
  output logic              align_fault_o,
  output logic              done_o
);
  localparam int SHIFT = $clog2(DATA_W / 8);

  logic              match_w, base_is_sp_w, misalign_w, idle_w;
  logic [IMM_W-1:0]  imm_w;
  logic [REG_W-1:0]  rn_w;
  logic [ADDR_W-1:0] ea_w;
  logic              hit_w, feats_ok_w, undef_now_w, fptrap_now_w, align_now_w, start_w;
  logic              second_w;
  vps_attr_t         attr_in_w, attr_out_w;
  logic              undef_q, fptrap_q, align_q;

  vps_decode #(.IMM_W(IMM_W), .REG_W(REG_W)) u_dec (
    .instr_i     (instr_i),
    .match_o     (match_w),
    .imm_o       (imm_w),
    .rn_o        (rn_w),
    .base_is_sp_o(base_is_sp_w)
  );

  vps_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHIFT(SHIFT)) u_agen (
    .imm_i        (imm_w),
    .base_is_sp_i (base_is_sp_w),
    .gpr_base_i   (gpr_base_i),
    .sp_i         (sp_i),
    .addr_o       (ea_w),
    .sp_misalign_o(misalign_w)
  );

  assign hit_w        = issue_i && idle_w && match_w;
  assign feats_ok_w   = feat_fp_i && feat_unpriv_i;
  assign undef_now_w  = hit_w && !feats_ok_w;
  assign fptrap_now_w = hit_w && feats_ok_w && !fp_enable_i;
  assign align_now_w  = hit_w && feats_ok_w && fp_enable_i && misalign_w;
  assign start_w      = hit_w && feats_ok_w && fp_enable_i && !misalign_w;

  assign attr_in_w.ntemp  = 1'b1;
  assign attr_in_w.tagchk = !base_is_sp_w;
  assign attr_in_w.unpriv = !uao_i;

  logic unused_rn;
  assign unused_rn = ^rn_w;

  vps_beat_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .addr_i  (ea_w),
    .data_a_i(vdata_a_i),
    .data_b_i(vdata_b_i),
    .attr_i  (attr_in_w),
    .ready_i (mem_ready_i),
    .idle_o  (idle_w),
    .valid_o (mem_valid_o),
    .second_o(second_w),
    .addr_o  (mem_addr_o),
    .data_o  (mem_wdata_o),
    .attr_o  (attr_out_w),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      undef_q  <= 1'b0;
      fptrap_q <= 1'b0;
      align_q  <= 1'b0;
    end else begin
      undef_q  <= undef_now_w;
      fptrap_q <= fptrap_now_w;
      align_q  <= align_now_w;
    end
  end

  assign undef_o       = undef_q;
  assign fp_trap_o     = fptrap_q;
  assign align_fault_o = align_q;
  assign mem_ntemp_o   = attr_out_w.ntemp;
  assign mem_tagchk_o  = attr_out_w.tagchk;
  assign mem_unpriv_o  = attr_out_w.unpriv;
endmodule

// File: rtl/vps_store_chk.sv
module vps_store_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic              ready,
  input logic              second,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] data,
  input logic              ntemp,
  input logic              done,
  input logic              undef,
  input logic              fptrap,
  input logic              align
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(addr) && $stable(data));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && !second |=> valid && second && (addr == $past(addr) + ADDR_W'(DATA_W / 8)));

  p_done_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(valid && ready && second));

  p_done_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ntemp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ntemp);

  p_fault_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef, fptrap, align}));

  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (undef || fptrap || align) |-> !valid);
endmodule

bind vpair_store_seq vps_store_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .valid (mem_valid_o),
  .ready (mem_ready_i),
  .second(second_w),
  .addr  (mem_addr_o),
  .data  (mem_wdata_o),
  .ntemp (mem_ntemp_o),
  .done  (done_o),
  .undef (undef_o),
  .fptrap(fp_trap_o),
  .align (align_fault_o)
);

// File: tb/vpair_store_seq_tb.sv
`timescale 1ns/1ps
module vpair_store_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic issue = 1'b0, fa = 1'b1, fb = 1'b1, fpe = 1'b1, uao = 1'b0, rdy = 1'b0;
  logic [31:0] ins = '0;
  logic [63:0] gbase = '0, sp = '0;
  logic [127:0] da = '0, db = '0;
  logic v, nt, tc, up, und, fpt, alf, dn;
  logic [63:0] addr;
  logic [127:0] wd;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vpair_store_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .instr_i(ins),
    .gpr_base_i(gbase), .sp_i(sp), .vdata_a_i(da), .vdata_b_i(db),
    .feat_fp_i(fa), .feat_unpriv_i(fb), .fp_enable_i(fpe), .uao_i(uao),
    .mem_ready_i(rdy), .mem_valid_o(v), .mem_addr_o(addr), .mem_wdata_o(wd),
    .mem_ntemp_o(nt), .mem_tagchk_o(tc), .mem_unpriv_o(up),
    .undef_o(und), .fp_trap_o(fpt), .align_fault_o(alf), .done_o(dn)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] imm, input logic [4:0] rn);
    return {10'b1110110000, imm, 5'd3, rn, 5'd7};
  endfunction

  task automatic quiet(input string req);
    chk(req, {v, und, fpt, alf, dn}, 5'b0);
  endtask

  // kind: 0 ignored, 1 undef, 2 fp trap, 3 align, 4 store
  task automatic run(input logic [31:0] w, input logic [63:0] b, input logic [63:0] s,
                     input logic [127:0] d0, input logic [127:0] d1,
                     input logic f1, input logic f2, input logic fp, input logic ua,
                     input int w0, input int w1, input bit poke_busy);
    logic [4:0] rn = w[9:5];
    logic [6:0] imm = w[21:15];
    longint sv = imm;
    logic [63:0] base, a;
    int kind;
    if (imm[6]) sv = sv - 128;
    base = (rn == 5'd31) ? s : b;
    a = base + 64'(sv * 16);
    if (w[31:22] != 10'b1110110000) kind = 0;
    else if (!(f1 && f2)) kind = 1;
    else if (!fp) kind = 2;
    else if (rn == 5'd31 && s[3:0] != 4'd0) kind = 3;
    else kind = 4;
    @(negedge clk);
    ins = w; gbase = b; sp = s; da = d0; db = d1; fa = f1; fb = f2; fpe = fp; uao = ua; issue = 1;
    @(negedge clk);
    issue = 0; gbase = ~b; sp = ~s; da = ~d0; db = ~d1; uao = ~ua; // R12 scramble
    case (kind)
      0: begin quiet("R1 ignored"); @(negedge clk); quiet("R1 ignored+1"); end
      1: begin chk("R8 undef", {v, und, fpt, alf}, 4'b0100); @(negedge clk); quiet("R8 pulse end"); end
      2: begin chk("R9 fptrap", {v, und, fpt, alf}, 4'b0010); @(negedge clk); quiet("R9 pulse end"); end
      3: begin chk("R10 align", {v, und, fpt, alf}, 4'b0001); @(negedge clk); quiet("R10 pulse end"); end
      default: begin
        chk("R5 beat0 valid", {v, dn, und, fpt, alf}, 5'b10000);
        chk("R2 R3 addr0", addr, a);
        chk("R5 R12 data0", wd, d0);
        chk("R4 attrs", {nt, tc, up}, {1'b1, rn != 5'd31, !ua});
        for (int i = 0; i < w0; i++) begin
          if (poke_busy && i == 0) begin ins = mk(7'h11, 5'd2); issue = 1; end
          @(negedge clk);
          issue = 0;
          chk("R6 R11 hold0", {v, addr, wd}, {1'b1, a, d0});
        end
        rdy = 1; @(negedge clk); rdy = 0;
        chk("R5 beat1", {v, dn, addr, wd}, {1'b1, 1'b0, a + 64'd16, d1});
        chk("R4 attrs1", {nt, tc, up}, {1'b1, rn != 5'd31, !ua});
        for (int i = 0; i < w1; i++) begin
          @(negedge clk);
          chk("R6 hold1", {v, addr, wd}, {1'b1, a + 64'd16, d1});
        end
        rdy = 1; @(negedge clk); rdy = 0;
        chk("R7 done", {v, dn}, 2'b01);
        @(negedge clk);
        chk("R7 R11 done end", {v, dn}, 2'b00);
      end
    endcase
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    quiet("R7 reset state");
    rst_n = 1;
    // R2 R3 R4 R5: sweep every immediate, base register and stall pattern
    for (int k = 0; k < 128; k++) begin
      logic [6:0] im = 7'(k);
      logic [4:0] rn = (k % 4 == 0) ? 5'd31 : 5'(k % 31);
      logic [63:0] b = (k % 2) ? 64'hFFFF_FFFF_FFFF_FFC0 + 64'(k) : 64'h0000_0100_0000_0000 + 64'(k * 3);
      run(mk(im, rn), b, 64'h0000_7FFF_FFFF_0000 + 64'(k * 16),
          {4{32'(k * 77)}}, {4{32'h5A5A_0000 + 32'(k)}}, 1, 1, 1, k[0], k % 3, (k / 3) % 3, k % 5 == 1);
    end
    // R2 wrap below zero and above 2^64
    run(mk(7'h40, 5'd4), 64'h0000_0000_0000_0100, 0, 128'h1, 128'h2, 1, 1, 1, 0, 0, 0, 0);
    run(mk(7'h3F, 5'd4), 64'hFFFF_FFFF_FFFF_FFF0, 0, 128'h3, 128'h4, 1, 1, 1, 1, 1, 0, 0);
    // R1: each opcode bit flipped
    for (int j = 0; j < 10; j++)
      run(mk(7'h5, 5'd1) ^ (32'h1 << (22 + j)), 64'h1000, 0, 1, 2, 1, 1, 1, 0, 0, 0, 0);
    // R8 feature combinations, with FP and alignment also bad
    run(mk(7'h1, 5'd31), 0, 64'h3, 1, 2, 0, 1, 0, 0, 0, 0, 0);
    run(mk(7'h1, 5'd2), 0, 0, 1, 2, 1, 0, 1, 0, 0, 0, 0);
    run(mk(7'h1, 5'd2), 0, 0, 1, 2, 0, 0, 1, 0, 0, 0, 0);
    // R9 beats alignment
    run(mk(7'h2, 5'd31), 0, 64'h8, 1, 2, 1, 1, 0, 0, 0, 0, 0);
    run(mk(7'h2, 5'd9), 0, 0, 1, 2, 1, 1, 0, 0, 0, 0, 0);
    // R10 every misaligned low nibble of the stack pointer
    for (int j = 1; j < 16; j++)
      run(mk(7'h7, 5'd31), 0, 64'h2000 + 64'(j), 1, 2, 1, 1, 1, 0, 0, 0, 0);
    // R10 misaligned general-register base is not faulted
    run(mk(7'h7, 5'd12), 64'h2005, 64'h3, 128'hAA, 128'hBB, 1, 1, 1, 0, 1, 1, 0);
    report();
  end
endmodule